// File: doc/BRIEF.md
# PLL Multiplier Code Converter

This block converts a PLL feedback multiplier between its plain binary value and the 17-bit code that the PLL hardware decodes. The code for a general multiplier is a state of a 15-bit linear shift sequence. It is reached by stepping a fixed seed a number of times that depends on the multiplier. A few small multipliers use fixed codes instead. The block works in both directions. In the encoding direction it also produces the two loop-bandwidth fields that go with the multiplier: a 5-bit proportional field and a 6-bit integral field.

A request goes in on a valid/ready channel. `in_dir` picks the direction: 0 encodes a multiplier, 1 decodes a code. The converter takes one sequence step per clock, so a request can occupy it for up to about 32 thousand cycles. While a request is in progress, `in_ready` stays low and no new request is taken. The result is offered on a valid/ready output channel. If the consumer holds `out_ready` low, the result stays on the outputs unchanged until it is taken. Only after the handshake does `in_ready` return high.

Top module: `pll_mcode_conv`

## Requirements
- R1: A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result has been handed over. While `out_valid` is high and `out_ready` is low, every result output holds its value. `in_ready` and `out_valid` are never high together.
- R2: Encoding (`in_dir`=0) maps the multiplier 0 to code 0x00000, 1 to 0x18003 and 2 to 0x10003.
- R3: Encoding a multiplier m from 3 to 32768 starts from x = 0x04000 and applies 32769−m steps. Each step replaces x with (((x XOR (x>>1)) AND 1) << 14) OR ((x>>1) AND 0xFFFF). The final x is the code.
- R4: Encoding a multiplier above 32768 returns code 0 with `out_invalid`=1, and both bandwidth fields are 0.
- R5: When encoding a valid multiplier m, `out_selp` is floor(m/2)+1 for m<60 and 31 otherwise.
- R6: When encoding a valid multiplier m, `out_seli` takes these values: 1 if m>16384, 2 if m>8192, 4 if m>2048, 8 if m≥501.
- R7: When encoding a multiplier m from 60 to 500, `out_seli` is 4t if (m+9)·t equals 1024 exactly, and 4(t+1) otherwise, where t = floor(1024/(m+9)). For m<60, `out_seli` is (m AND 0x3C)+4.
- R8: Decoding (`in_dir`=1) maps code 0x18003 to 1 and code 0x10003 to 2.
- R9: Decoding any other code x uses a counter c that starts at 32769. While x differs from 0x04000 and c>0, the block replaces x with ((x XOR (x>>14)) AND 1) OR ((x<<1) AND 0x7FFF) and decrements c. A final c greater than 0 is the result, and `out_invalid` is 0.
- R10: A decode in which the counter reaches 0 returns 0 with `out_invalid`=1.
- R11: A decode always returns both bandwidth fields as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Converter idle and able to take a request |
| in_dir | input | 1 | 0 = multiplier to code, 1 = code to multiplier |
| in_value | input | 17 | Multiplier (encode) or code (decode) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_code | output | 17 | Code (encode) or multiplier (decode) |
| out_selp | output | 5 | Proportional bandwidth field (encode only) |
| out_seli | output | 6 | Integral bandwidth field (encode only) |
| out_invalid | output | 1 | Input out of range or code not on the sequence |

## Verification
The hardest cases to reach are the small multipliers. They need the longest walk, over 32 thousand sequence steps, and they are the only multipliers whose integral field comes from the ceiling division or from the masked low-bits rule. The stimulus therefore spends most of its cycle budget on a few chosen small multipliers (45, 100, 501). Multipliers near the top of the range cover the short walks. Decoding the code 0, which is not on the sequence, drives the counter all the way to exhaustion. Back-pressure is applied to a fixed-code result so that the hold on a stalled output can be seen without a long wait.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned CODE_W   = 17;
  localparam int unsigned SELP_W   = 5;
  localparam int unsigned SELI_W   = 6;
  localparam int unsigned MSEL_TOP = 32768;
  localparam logic [CODE_W-1:0] SEED_CODE = 17'h04000;
  localparam logic [CODE_W-1:0] CODE_ONE  = 17'h18003;
  localparam logic [CODE_W-1:0] CODE_TWO  = 17'h10003;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} pmc_state_e;
  typedef enum logic [1:0] {K_WALK, K_FIXED, K_BAD} pmc_kind_e;
endpackage

// File: rtl/pmc_walk.sv
module pmc_walk
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              dec_mode,
  input  logic [CODE_W-1:0] x_init,
  input  logic [CODE_W-1:0] cnt_init,
  output logic [CODE_W-1:0] x_q,
  output logic [CODE_W-1:0] cnt_q,
  output logic              done
);
  logic              mode_q;
  logic [CODE_W-1:0] enc_next;
  logic [CODE_W-1:0] dec_next;

  // forward step: shift right, feedback into bit 14
  always_comb begin
    enc_next       = '0;
    enc_next[15:0] = x_q[16:1];
    enc_next[14]   = x_q[15] | (x_q[0] ^ x_q[1]);
  end

  // reverse step: shift left within 15 bits, feedback into bit 0
  always_comb begin
    dec_next       = '0;
    dec_next[14:1] = x_q[13:0];
    dec_next[0]    = x_q[0] ^ x_q[14];
  end

  assign done = mode_q ? ((x_q == SEED_CODE) || (cnt_q == '0)) : (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      x_q    <= x_init;
      cnt_q  <= cnt_init;
      mode_q <= dec_mode;
    end else if (!done) begin
      x_q    <= mode_q ? dec_next : enc_next;
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pmc_bw.sv
module pmc_bw
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] msel,
  output logic [SELP_W-1:0] selp,
  output logic [SELI_W-1:0] seli,
  output logic              done
);
  localparam int unsigned REM_W = 11;
  localparam int unsigned Q_W   = 5;

  logic [CODE_W-1:0] m_q;
  logic [REM_W-1:0]  rem_q;
  logic [Q_W-1:0]    q_q;
  logic              busy_q;
  logic [REM_W-1:0]  dvs;

  assign dvs  = {1'b0, m_q[9:0]} + 11'd9;
  assign done = !busy_q;

  // iterative ceiling of 1024 / (m + 9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q    <= '0;
      rem_q  <= '0;
      q_q    <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      m_q    <= msel;
      rem_q  <= 11'd1024;
      q_q    <= '0;
      busy_q <= (msel >= 17'd60) && (msel <= 17'd500);
    end else if (busy_q) begin
      q_q <= q_q + 1'b1;
      if (rem_q > dvs) rem_q <= rem_q - dvs;
      else             busy_q <= 1'b0;
    end
  end

  always_comb begin
    if (m_q < 17'd60) selp = m_q[5:1] + 5'd1;
    else              selp = 5'd31;
  end

  always_comb begin
    if      (m_q > 17'd16384) seli = 6'd1;
    else if (m_q > 17'd8192)  seli = 6'd2;
    else if (m_q > 17'd2048)  seli = 6'd4;
    else if (m_q >= 17'd501)  seli = 6'd8;
    else if (m_q >= 17'd60)   seli = {q_q[3:0], 2'b00};
    else                      seli = (m_q[5:0] & 6'h3c) + 6'd4;
  end
endmodule

// File: rtl/pll_mcode_conv.sv
module pll_mcode_conv
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_dir,
  input  logic [CODE_W-1:0] in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CODE_W-1:0] out_code,
  output logic [SELP_W-1:0] out_selp,
  output logic [SELI_W-1:0] out_seli,
  output logic              out_invalid
);
  localparam logic [CODE_W-1:0] TOP_V   = CODE_W'(MSEL_TOP);
  localparam logic [CODE_W-1:0] START_C = CODE_W'(MSEL_TOP + 1);

  pmc_state_e        state_q;
  pmc_kind_e         kind_q, kind_d;
  logic              dir_q;
  logic [CODE_W-1:0] fixed_q, fixed_d;
  logic              accept;
  logic              w_mode;
  logic [CODE_W-1:0] w_x0, w_c0, w_x, w_c;
  logic              w_done;
  logic [SELP_W-1:0] bw_selp;
  logic [SELI_W-1:0] bw_seli;
  logic              bw_done;
  logic              finish;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign accept    = in_valid && in_ready;
  assign finish    = (state_q == ST_RUN) && w_done && bw_done;

  // classify request and set up the walk
  always_comb begin
    kind_d  = K_WALK;
    fixed_d = '0;
    w_mode  = 1'b0;
    w_x0    = SEED_CODE;
    w_c0    = '0;
    if (!in_dir) begin
      if (in_value > TOP_V) begin
        kind_d = K_BAD;
      end else if (in_value == 17'd0) begin
        kind_d = K_FIXED;
      end else if (in_value == 17'd1) begin
        kind_d = K_FIXED; fixed_d = CODE_ONE;
      end else if (in_value == 17'd2) begin
        kind_d = K_FIXED; fixed_d = CODE_TWO;
      end else begin
        w_c0 = START_C - in_value;
      end
    end else begin
      if (in_value == CODE_ONE) begin
        kind_d = K_FIXED; fixed_d = 17'd1;
      end else if (in_value == CODE_TWO) begin
        kind_d = K_FIXED; fixed_d = 17'd2;
      end else begin
        w_mode = 1'b1;
        w_x0   = in_value;
        w_c0   = START_C;
      end
    end
  end

  pmc_walk u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .dec_mode (w_mode),
    .x_init   (w_x0),
    .cnt_init (w_c0),
    .x_q      (w_x),
    .cnt_q    (w_c),
    .done     (w_done)
  );

  pmc_bw u_bw (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept && !in_dir),
    .msel  (in_value),
    .selp  (bw_selp),
    .seli  (bw_seli),
    .done  (bw_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= K_WALK;
      dir_q       <= 1'b0;
      fixed_q     <= '0;
      out_code    <= '0;
      out_selp    <= '0;
      out_seli    <= '0;
      out_invalid <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          kind_q  <= kind_d;
          dir_q   <= in_dir;
          fixed_q <= fixed_d;
        end
        ST_RUN: if (finish) begin
          state_q <= ST_HOLD;
          case (kind_q)
            K_FIXED: begin out_code <= fixed_q; out_invalid <= 1'b0; end
            K_BAD:   begin out_code <= '0;      out_invalid <= 1'b1; end
            default: begin
              if (dir_q) begin
                out_code    <= w_c;
                out_invalid <= (w_c == '0);
              end else begin
                out_code    <= w_x;
                out_invalid <= 1'b0;
              end
            end
          endcase
          if (dir_q || kind_q == K_BAD) begin
            out_selp <= '0;
            out_seli <= '0;
          end else begin
            out_selp <= bw_selp;
            out_seli <= bw_seli;
          end
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk
  import pmc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code,
  input logic [SELP_W-1:0] out_selp,
  input logic [SELI_W-1:0] out_seli,
  input logic              out_invalid,
  input logic              dir_q
);
  // R1
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code) && $stable(out_selp)
                                && $stable(out_seli) && $stable(out_invalid));

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R4
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_code == '0 && out_selp == '0 && out_seli == '0);

  // R11
  decode_bw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dir_q |-> out_selp == '0 && out_seli == '0);

  // R7
  seli_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !dir_q && !out_invalid |->
      out_seli == 6'd1 || out_seli == 6'd2 || (out_seli[1:0] == 2'b00 && out_seli != '0));

  // R5
  selp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !dir_q && !out_invalid |-> out_selp != '0);
endmodule

bind pll_mcode_conv pmc_chk u_chk (.*);

// File: tb/sim_pll_mcode_conv.sv
`timescale 1ns/1ps
module sim_pll_mcode_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [16:0] in_value = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [16:0] out_code;
  logic [4:0]  out_selp;
  logic [5:0]  out_seli;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  typedef struct {
    int    code;
    int    selp;
    int    seli;
    int    inv;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  pll_mcode_conv u0 (.*);

  function automatic int enc_m(int m);
    int x;
    if (m == 0) return 0;
    if (m == 1) return 'h18003;
    if (m == 2) return 'h10003;
    x = 'h4000;
    for (int i = m; i <= 32768; i++) x = (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'hffff);
    return x;
  endfunction

  function automatic int dec_m(int v);
    int x;
    int c;
    if (v == 'h18003) return 1;
    if (v == 'h10003) return 2;
    x = v;
    for (c = 32769; x != 'h4000 && c > 0; c--) x = ((x ^ (x >> 14)) & 1) | ((x << 1) & 'h7fff);
    return c;
  endfunction

  function automatic int selp_m(int m);
    return (m < 60) ? (m / 2 + 1) : 31;
  endfunction

  function automatic int seli_m(int m);
    int t;
    if (m > 16384) return 1;
    if (m > 8192) return 2;
    if (m > 2048) return 4;
    if (m >= 501) return 8;
    if (m >= 60) begin
      t = 1024 / (m + 9);
      return (t * (m + 9) == 1024) ? 4 * t : 4 * (t + 1);
    end
    return (m & 'h3c) + 4;
  endfunction

  task automatic push_req(bit d, int v, string tag);
    exp_t e;
    e.tag = tag;
    if (!d) begin
      if (v > 32768) begin e.code = 0; e.selp = 0; e.seli = 0; e.inv = 1; end
      else begin e.code = enc_m(v); e.selp = selp_m(v); e.seli = seli_m(v); e.inv = 0; end
    end else begin
      e.code = dec_m(v); e.selp = 0; e.seli = 0; e.inv = (e.code == 0);
    end
    sb.push_back(e);
    @(posedge clk); #1;
    in_valid = 1'b1; in_dir = d; in_value = 17'(v);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_value = '0;
  endtask

  task automatic run(bit d, int v, string tag);
    push_req(d, v, tag);
    wait (sb.size() == 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      exp_t e;
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected result code=%0h", out_code);
      end else begin
        e = sb.pop_front();
        checks++;
        if (int'(out_code) != e.code || int'(out_selp) != e.selp ||
            int'(out_seli) != e.seli || int'(out_invalid) != e.inv) begin
          errors++;
          $display("FAIL %s code=%0h selp=%0d seli=%0d inv=%0d expected code=%0h selp=%0d seli=%0d inv=%0d",
                   e.tag, out_code, out_selp, out_seli, out_invalid, e.code, e.selp, e.seli, e.inv);
        end
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (!in_ready || out_valid) begin
      errors++;
      $display("FAIL R1 reset in_ready=%0d out_valid=%0d expected 1 0", in_ready, out_valid);
    end

    run(0, 0, "R2 enc 0");
    run(0, 2, "R2 R5 R7 enc 2");
    run(0, 32768, "R3 R6 enc 32768");
    run(0, 32767, "R3 enc 32767");
    run(0, 40000, "R4 enc out of range");
    run(0, 32769, "R4 enc 32769");
    run(0, 20000, "R3 R6 enc 20000");
    run(1, 'h18003, "R8 dec one");
    run(1, 'h10003, "R8 dec two");
    run(1, enc_m(32768), "R9 R11 dec of 32768");
    run(1, enc_m(30000), "R9 dec of 30000");
    run(0, 501, "R5 R6 enc 501");
    run(0, 100, "R7 enc 100");
    run(0, 45, "R5 R7 enc 45");
    run(1, 0, "R10 dec exhaust");

    // R1 back-pressure on a fixed-code result
    @(posedge clk); #1 out_ready = 1'b0;
    push_req(0, 1, "R1 R2 enc 1 after stall");
    forever begin
      @(negedge clk);
      if (out_valid) break;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (!out_valid || in_ready || out_code != 17'h18003) begin
      errors++;
      $display("FAIL R1 stall valid=%0d ready=%0d code=%0h expected 1 0 18003",
               out_valid, in_ready, out_code);
    end
    @(posedge clk); #1 out_ready = 1'b1;
    wait (sb.size() == 0);
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (!in_ready || out_valid) begin
      errors++;
      $display("FAIL R1 after release in_ready=%0d out_valid=%0d expected 1 0", in_ready, out_valid);
    end
    finish_run();
  end
endmodule